// File: doc/BRIEF.md
# Register-Programmed Event Routing Crossbar

This block connects a set of single-bit event sources to a set of single-bit event sinks inside a chip. Each sink (output) owns one 32-bit control word on a small synchronous register bus. The word names the source it follows and carries a route enable. Any number of outputs may follow the same input, so one event can fan out to several consumers. Software sets up a route in two writes. The first writes the input index with the enable clear. The second repeats the write with the enable set. To tear the route down, software clears the enable again.

Every routed output passes through one flop. A change of input or of route therefore reaches the pin on a clock edge, and a new select value never glitches an output through logic. The number of inputs (up to 64) and of outputs (up to 48) are parameters. The bus address width must be large enough to reach the word of the last output.

Top module: `evt_xbar`

## Requirements
- R1: After a synchronous reset, every control word reads 0, and from the first clock edge with reset high every output is 0.
- R2: The control word of output n is at byte offset 4*n+4 (word index n+1), and address bits [1:0] are ignored. Bits [5:0] hold the input index and bit 16 is the route enable.
- R3: Control word bits other than [5:0] and 16 always read 0, and writes to them have no effect.
- R4: Writes to word index 0 and to word indices above the last output change no control word. Reads from those indices return 0.
- R5: While output n is enabled with an index s below the input count, evt_out[n] equals evt_in[s] as sampled at the previous clock edge.
- R6: An enabled output whose index is equal to or greater than the input count drives 0.
- R7: An output whose enable bit is clear drives 0 whatever its index. Writing the index first and then setting the enable creates the route.
- R8: Several outputs may select the same input at once, and each of them follows it.
- R9: A write to one output's control word leaves every other output's word and routed value unchanged.
- R10: bus_rdata is registered. It shows the addressed word on the clock edge after bus_rd_en is sampled high, and holds its value while bus_rd_en is low.
- R11: A change on an input reaches an enabled output exactly one clock edge later, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for one clock cycle |
| bus_rd_en | input | 1 | Read strobe for one clock cycle |
| bus_addr | input | ADDR_W | Byte address of the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | NUM_IN | Event sources |
| evt_out | output | NUM_OUT | Registered routed events |

## Verification
The routing assertions assume that evt_in has settled by the clock edge, so that a sampled value is the one a flop captures. The bench changes inputs only at falling edges and never drives X on the event lines. The read-path assertions assume that bus_addr is stable whenever bus_rd_en is high. The bench keeps the address and the strobe together for a whole cycle, and it reaches every address the decoder cares about, including word 0 and the first word past the last output.

// File: rtl/evt_xbar_pkg.sv
package evt_xbar_pkg;

    localparam int SEL_W  = 6;
    localparam int EN_POS = 16;
    localparam int BUS_W  = 32;
    localparam logic [BUS_W-1:0] LIVE_MASK = 32'h0001_003F;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } route_cfg_t;

    function automatic route_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        route_cfg_t c;
        c.en  = w[EN_POS];
        c.sel = w[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input route_cfg_t c);
        logic [BUS_W-1:0] w;
        w             = '0;
        w[SEL_W-1:0]  = c.sel;
        w[EN_POS]     = c.en;
        return w;
    endfunction

endpackage

// File: rtl/evt_xbar_regs.sv
module evt_xbar_regs
    import evt_xbar_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr_en,
    input  logic                     bus_rd_en,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    output route_cfg_t [NUM_OUT-1:0] cfg_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic [BUS_W-1:0]  rd_word;

    // Word index n+1 belongs to output n; index 0 and those past the end decode to nothing.
    assign word_idx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (bus_wr_en) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (word_idx == WORD_W'(i + 1)) begin
                    cfg_o[i] <= cfg_from_word(bus_wdata);
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (word_idx == WORD_W'(i + 1)) begin
                rd_word = cfg_to_word(cfg_o[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/evt_xbar_lane.sv
module evt_xbar_lane
    import evt_xbar_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] evt_in,
    input  route_cfg_t        cfg,
    output logic              evt_q
);
    logic pick;

    // Index values past the last input match no branch and leave pick at 0.
    always_comb begin
        pick = 1'b0;
        if (cfg.en) begin
            for (int i = 0; i < NUM_IN; i++) begin
                if (cfg.sel == SEL_W'(i)) begin
                    pick = evt_in[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= pick;
        end
    end

endmodule

// File: rtl/evt_xbar.sv
module evt_xbar
    import evt_xbar_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IN-1:0]  evt_in,
    output logic [NUM_OUT-1:0] evt_out
);
    route_cfg_t [NUM_OUT-1:0] ctrl_cfg;

    evt_xbar_regs #(
        .NUM_OUT (NUM_OUT),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (ctrl_cfg)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        evt_xbar_lane #(
            .NUM_IN (NUM_IN)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .evt_in (evt_in),
            .cfg    (ctrl_cfg[g]),
            .evt_q  (evt_out[g])
        );
    end

endmodule

// File: rtl/evt_xbar_chk.sv
module evt_xbar_chk
    import evt_xbar_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 6,
    parameter int ADDR_W  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_rd_en,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [31:0]              bus_rdata,
    input logic [NUM_IN-1:0]        evt_in,
    input logic [NUM_OUT-1:0]       evt_out,
    input route_cfg_t [NUM_OUT-1:0] ctrl_cfg
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (evt_out == '0 && bus_rdata == '0)); // R1
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rdata & ~LIVE_MASK) == '0); // R3
    AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && (int'(bus_addr[ADDR_W-1:2]) == 0 || int'(bus_addr[ADDR_W-1:2]) > NUM_OUT)
        |=> bus_rdata == '0); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !bus_rd_en |=> $stable(bus_rdata)); // R10

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
            !ctrl_cfg[n].en |=> !evt_out[n]); // R7
        AST_OOR_SEL_LOW: assert property (@(posedge clk) disable iff (rst)
            ctrl_cfg[n].en && int'(ctrl_cfg[n].sel) >= NUM_IN |=> !evt_out[n]); // R6
        AST_ROUTE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            ctrl_cfg[n].en && int'(ctrl_cfg[n].sel) < NUM_IN
            |=> evt_out[n] == $past(evt_in[ctrl_cfg[n].sel])); // R5 R11
    end

endmodule

bind evt_xbar evt_xbar_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .evt_out   (evt_out),
    .ctrl_cfg  (ctrl_cfg)
);

// File: tb/evt_xbar_bench.sv
module evt_xbar_bench;
    localparam int NI = 8;
    localparam int NO = 6;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr_en, bus_rd_en;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NI-1:0] evt_in;
    logic [NO-1:0] evt_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [NO];

    always #2 clk = ~clk;

    evt_xbar #(.NUM_IN(NI), .NUM_OUT(NO), .ADDR_W(AW)) u_evt_xbar (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .evt_out(evt_out)
    );

    function automatic logic [AW-1:0] off(input int n);
        return AW'(4 * n + 4);
    endfunction

    function automatic logic [NO-1:0] expect_out(input logic [NI-1:0] v);
        logic [NO-1:0] r;
        for (int n = 0; n < NO; n++) begin
            int s;
            s    = int'(mdl[n][5:0]);
            r[n] = (mdl[n][16] && s < NI) ? v[s] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        int w;
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        w = int'(a[AW-1:2]);
        if (w >= 1 && w <= NO) mdl[w-1] = d & 32'h0001_003F;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        bus_read(a, d);
        check(d === exp, req, d, exp);
    endtask

    task automatic regs_match(input string req);
        for (int n = 0; n < NO; n++) read_expect(off(n), mdl[n], req);
    endtask

    task automatic apply(input logic [NI-1:0] v, input string req);
        logic [NO-1:0] e;
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        e = expect_out(v);
        check(evt_out === e, req, 32'(evt_out), 32'(e));
    endtask

    task automatic clear_all();
        for (int n = 0; n < NO; n++) bus_write(off(n), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        bus_addr = '0; bus_wdata = '0; evt_in = '1;
        for (int n = 0; n < NO; n++) mdl[n] = '0;
        repeat (3) @(negedge clk);
        check(evt_out === '0, "R1 outputs in reset", 32'(evt_out), 0);
        rst = 1'b0;

        // R1: all words zero, all outputs low with inputs high
        regs_match("R1 reset word");
        apply('1, "R1 outputs after reset");

        // R3: reserved bits read 0; R2 field positions
        for (int n = 0; n < NO; n++) begin
            bus_write(off(n), 32'hFFFF_FFFF);
            read_expect(off(n), 32'h0001_003F, "R3 reserved bits");
        end
        clear_all();
        // R2: low address bits ignored, offset 4n+4
        bus_write(off(1) + AW'(3), 32'h0001_0002);
        read_expect(off(1), 32'h0001_0002, "R2 addr[1:0] ignored");
        apply(8'h04, "R2 route via offset 4n+4");
        clear_all();

        // R4: holes ignored and read zero
        bus_write(off(2), 32'h0001_0005);
        bus_write(AW'(0), 32'hFFFF_FFFF);
        bus_write(off(NO), 32'hFFFF_FFFF);
        read_expect(AW'(0), 32'h0, "R4 read offset 0");
        read_expect(off(NO), 32'h0, "R4 read past end");
        regs_match("R4 words untouched");
        clear_all();

        // R7: program order, index first then enable
        bus_write(off(2), 32'h0000_0003);
        apply('1, "R7 disabled output low");
        bus_write(off(2), 32'h0001_0003);
        apply(8'h08, "R7 enabled after second write");
        apply(8'hF7, "R7 enabled after second write");
        clear_all();

        // R5/R6 sweep per output and index
        for (int n = 0; n < NO; n++) begin
            for (int s = 0; s < NI + 2; s++) begin
                bus_write(off(n), 32'h0001_0000 | 32'(s));
                for (int p = 0; p < NI; p++) begin
                    apply(NI'(1) << p, s < NI ? "R5 onehot route" : "R6 index out of range");
                    apply(~(NI'(1) << p), s < NI ? "R5 inverse route" : "R6 index out of range");
                end
            end
            bus_write(off(n), 32'h0);
        end

        // R8: fan-out of one input to every output
        for (int n = 0; n < NO; n++) bus_write(off(n), 32'h0001_0005);
        apply(8'h20, "R8 fan-out high");
        apply(8'hDF, "R8 fan-out low");

        // Mixed configuration, exhaustive input patterns
        for (int n = 0; n < NO; n++)
            bus_write(off(n), ((n % 3 != 2) ? 32'h0001_0000 : 32'h0) | 32'((n * 3 + 1) % (NI + 2)));
        for (int v = 0; v < (1 << NI); v++) apply(NI'(v), "R5 exhaustive mixed");

        // R9: tear down one route, others keep their words and values
        bus_write(off(0), 32'h0);
        regs_match("R9 other words unchanged");
        for (int v = 0; v < (1 << NI); v += 17) apply(NI'(v), "R9 isolation");

        // R11: exactly one edge of latency
        for (int n = 0; n < NO; n++) bus_write(off(n), 32'h0001_0000 | 32'(n));
        apply(8'h00, "R11 baseline");
        @(negedge clk);
        evt_in = 8'hFF;
        #1;
        check(evt_out === '0, "R11 no early change", 32'(evt_out), 0);
        @(negedge clk);
        check(evt_out === expect_out(8'hFF), "R11 change after one edge", 32'(evt_out), 32'(expect_out(8'hFF)));

        // R10: read data holds between reads
        bus_read(off(3), d);
        check(d === mdl[3], "R10 read value", d, mdl[3]);
        bus_write(off(3), 32'h0001_0001);
        repeat (3) @(negedge clk);
        check(bus_rdata === 32'h0001_0003, "R10 rdata held", bus_rdata, 32'h0001_0003);
        read_expect(off(3), 32'h0001_0001, "R10 new read");

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int n = 0; n < NO; n++) mdl[n] = '0;
        regs_match("R1 reset clears words");
        apply('1, "R1 reset clears outputs");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule